// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Condition Flags

This unit performs integer division for a processor execution stage. It accepts one operation at a time through a start pulse. Each operation carries a form, a signedness bit, the operands, the two destination register numbers and the current Z and N flag values. Three forms exist. The word form divides 32 bits by 16 bits and packs both results into one register. The long form divides 32 bits by 32 bits. The quad form divides a 64-bit value, held in a register pair, by 32 bits.

Internally the unit works on magnitudes. It produces one quotient bit per clock with a shift-and-subtract loop, then restores the signs. After that it reports which destinations the register file should write and with what data. It also reports new Z, N, V and C values, or it raises a divide-by-zero exception instead.

Control is plain: `busy` is high while an operation is in flight, and `done` is a single-cycle pulse. There is no back-pressure on the result side. Whatever the unit reports in the `done` cycle must be consumed in that cycle. A start pulse that arrives while `busy` is high is dropped.

Top module: `seqdiv_unit`

## Requirements
- R1: A start is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the result cycle. `done` lasts exactly one cycle, with `busy` low. A start raised while `busy` is high produces no extra result and does not disturb the running one.
- R2: If the effective divisor is zero, the unit asserts `div0_exc` together with `done`. In that cycle `wq_en`, `wr_en` and `flag_we` stay low. In word form the effective divisor is `divisor[15:0]` only.
- R3: Form code `mode`=2'b00 is the word form. `dvd_lo` (32 bits) is divided by `divisor[15:0]`. `wq_data` carries the remainder in bits 31:16 and the quotient in bits 15:0. `wr_en` is never asserted in this form.
- R4: Word-form overflow occurs in two cases. Unsigned, it occurs when the quotient exceeds 0xFFFF. Signed, it occurs when the quotient lies outside -32768..32767.
- R5: Form code 2'b01 is the long form. `dvd_lo` is divided by the full `divisor`. The quotient goes to `wq_data` and the remainder to `wr_data`. When `r_idx` equals `q_idx`, only the quotient is written. Signed overflow occurs only when the quotient is +2^31.
- R6: Form code 2'b10 is the quad form, and its dividend is {`dvd_hi`,`dvd_lo`}. Unsigned overflow occurs when the quotient exceeds 0xFFFFFFFF. Signed overflow occurs when quotient bits 63:31 are neither all zeros nor all ones. The same-register rule of R5 applies.
- R7: Signed division truncates toward zero, and the remainder carries the sign of the dividend.
- R8: Every completion with a nonzero divisor asserts `flag_we`. In that cycle `flag_c` is 0 and `flag_v` equals the overflow condition.
- R9: Without overflow, `flag_z` is 1 when quotient bits 31:0 are zero. `flag_n` is quotient bit 15 in word form and bit 31 otherwise. With overflow, `flag_z` and `flag_n` repeat the `z_in` and `n_in` values given at start.
- R10: On overflow, `wq_en` and `wr_en` stay low.
- R11: `done` appears a fixed number of cycles after the accepting clock edge: 1 for a zero divisor, 33 for the word and long forms, and 65 for the quad form.
- R12: `wq_sel` and `wr_sel` return the `q_idx` and `r_idx` given at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when not busy) |
| mode | input | 2 | Form: 00 word, 01 long, 10 quad |
| is_signed | input | 1 | Signed operation |
| dvd_hi | input | 32 | Remainder-register value, dividend high word in quad form |
| dvd_lo | input | 32 | Quotient-register value, dividend (low word in quad form) |
| divisor | input | 32 | Divisor (low 16 bits in word form) |
| q_idx | input | 3 | Quotient destination register number |
| r_idx | input | 3 | Remainder destination register number |
| z_in | input | 1 | Current Z flag |
| n_in | input | 1 | Current N flag |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle result pulse |
| div0_exc | output | 1 | Divide-by-zero exception, with done |
| wq_en | output | 1 | Write quotient destination |
| wq_sel | output | 3 | Quotient destination register number |
| wq_data | output | 32 | Quotient data (packed rem:quot in word form) |
| wr_en | output | 1 | Write remainder destination |
| wr_sel | output | 3 | Remainder destination register number |
| wr_data | output | 32 | Remainder data |
| flag_we | output | 1 | Update condition flags |
| flag_z | output | 1 | Z result |
| flag_n | output | 1 | N result |
| flag_v | output | 1 | V result (overflow) |
| flag_c | output | 1 | C result (always 0) |

## Verification
The assertions assume that `mode` never carries the unused code 2'b11 when a start is accepted. They also assume that operands, flags and register numbers are stable in the cycle `start` is sampled. The bench keeps to this: it drives every input at the falling edge, uses only the three defined form codes, and holds the values until `start` drops. Both the result latency check and the flag-hold check depend on what was captured at acceptance. Because of that, stray starts during `busy` are sent only through the normal ports, never forced.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
  typedef enum logic [1:0] {
    DM_WORD = 2'b00,
    DM_LONG = 2'b01,
    DM_QUAD = 2'b10
  } dmode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } dstate_e;
endpackage

// File: rtl/seqdiv_prep.sv
// Operand conditioning: sign extraction, magnitudes, zero test, step count.
module seqdiv_prep
  import seqdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 7
) (
  input  dmode_e            mode,
  input  logic              sgn,
  input  logic [DW-1:0]     hi,
  input  logic [DW-1:0]     lo,
  input  logic [DW-1:0]     dvs,
  output logic [2*DW-1:0]   dvd_mag,
  output logic [DW-1:0]     dvs_mag,
  output logic              q_neg,
  output logic              r_neg,
  output logic              dvs_zero,
  output logic [CW-1:0]     steps
);
  localparam int HW = DW / 2;

  logic [DW-1:0]   dvs_ext;
  logic [2*DW-1:0] wide;
  logic [DW-1:0]   narrow;
  logic            dvd_neg;
  logic            dvs_neg;

  always_comb begin
    if (mode == DM_WORD)
      dvs_ext = sgn ? {{HW{dvs[HW-1]}}, dvs[HW-1:0]} : {{HW{1'b0}}, dvs[HW-1:0]};
    else
      dvs_ext = dvs;
    dvd_neg  = sgn & ((mode == DM_QUAD) ? hi[DW-1] : lo[DW-1]);
    dvs_neg  = sgn & dvs_ext[DW-1];
    wide     = dvd_neg ? -{hi, lo} : {hi, lo};
    narrow   = dvd_neg ? -lo : lo;
    if (mode == DM_QUAD) begin
      dvd_mag = wide;
      steps   = CW'(2 * DW);
    end else begin
      // left-align so the quotient lands in the low half after DW steps
      dvd_mag = {narrow, {DW{1'b0}}};
      steps   = CW'(DW);
    end
    dvs_mag  = dvs_neg ? -dvs_ext : dvs_ext;
    dvs_zero = (dvs_ext == '0);
    q_neg    = dvd_neg ^ dvs_neg;
    r_neg    = dvd_neg;
  end
endmodule

// File: rtl/seqdiv_core.sv
// Radix-2 restoring engine: one quotient bit per step.
module seqdiv_core #(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [2*DW-1:0]   dvd_in,
  input  logic [DW-1:0]     dvs_in,
  output logic [2*DW-1:0]   quo,
  output logic [DW-1:0]     rem
);
  logic [2*DW-1:0] shreg;
  logic [DW-1:0]   part;
  logic [DW-1:0]   dvs_q;
  logic [DW:0]     trial;
  logic [DW:0]     diff;
  logic            fits;

  assign trial = {part, shreg[2*DW-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = ~diff[DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      part  <= '0;
      dvs_q <= '0;
    end else if (load) begin
      shreg <= dvd_in;
      part  <= '0;
      dvs_q <= dvs_in;
    end else if (step) begin
      shreg <= {shreg[2*DW-2:0], fits};
      part  <= fits ? diff[DW-1:0] : trial[DW-1:0];
    end
  end

  assign quo = shreg;
  assign rem = part;
endmodule

// File: rtl/seqdiv_post.sv
// Sign restoration, overflow detection, flag and write-enable formation.
module seqdiv_post
  import seqdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 3
) (
  input  dmode_e            mode,
  input  logic              sgn,
  input  logic [2*DW-1:0]   quo_mag,
  input  logic [DW-1:0]     rem_mag,
  input  logic              q_neg,
  input  logic              r_neg,
  input  logic [IW-1:0]     qi,
  input  logic [IW-1:0]     ri,
  input  logic              old_z,
  input  logic              old_n,
  output logic [DW-1:0]     q_data,
  output logic [DW-1:0]     r_data,
  output logic              q_we,
  output logic              r_we,
  output logic              z,
  output logic              n,
  output logic              v
);
  localparam int HW = DW / 2;

  logic [2*DW-1:0] qs;
  logic [DW-1:0]   rs;
  logic            is_word;

  always_comb begin
    qs      = q_neg ? -quo_mag : quo_mag;
    rs      = r_neg ? -rem_mag : rem_mag;
    is_word = (mode == DM_WORD);
    if (is_word)
      v = sgn ? !((&qs[2*DW-1:HW-1]) | ~(|qs[2*DW-1:HW-1])) : (|qs[2*DW-1:HW]);
    else
      v = sgn ? !((&qs[2*DW-1:DW-1]) | ~(|qs[2*DW-1:DW-1])) : (|qs[2*DW-1:DW]);
    q_data = is_word ? {rs[HW-1:0], qs[HW-1:0]} : qs[DW-1:0];
    r_data = rs;
    q_we   = !v;
    // remainder first, quotient second: a shared register keeps the quotient
    r_we   = !v && !is_word && (ri != qi);
    z      = v ? old_z : (qs[DW-1:0] == '0);
    n      = v ? old_n : (is_word ? qs[HW-1] : qs[DW-1]);
  end
endmodule

// File: rtl/seqdiv_unit.sv
module seqdiv_unit
  import seqdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          is_signed,
  input  logic [DW-1:0] dvd_hi,
  input  logic [DW-1:0] dvd_lo,
  input  logic [DW-1:0] divisor,
  input  logic [IW-1:0] q_idx,
  input  logic [IW-1:0] r_idx,
  input  logic          z_in,
  input  logic          n_in,
  output logic          busy,
  output logic          done,
  output logic          div0_exc,
  output logic          wq_en,
  output logic [IW-1:0] wq_sel,
  output logic [DW-1:0] wq_data,
  output logic          wr_en,
  output logic [IW-1:0] wr_sel,
  output logic [DW-1:0] wr_data,
  output logic          flag_we,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_v,
  output logic          flag_c
);
  localparam int CW = $clog2(2 * DW + 1);

  dstate_e         state;
  dmode_e          mode_in;
  dmode_e          mode_q;
  logic [CW-1:0]   cnt;
  logic            sgn_q, qneg_q, rneg_q, dz_q, oz_q, on_q;
  logic [IW-1:0]   qi_q, ri_q;

  logic [2*DW-1:0] p_dvd;
  logic [DW-1:0]   p_dvs;
  logic            p_qneg, p_rneg, p_zero;
  logic [CW-1:0]   p_steps;
  logic [2*DW-1:0] c_quo;
  logic [DW-1:0]   c_rem;
  logic [DW-1:0]   f_qd, f_rd;
  logic            f_qwe, f_rwe, f_z, f_n, f_v;
  logic            accept;

  assign mode_in = dmode_e'(mode);
  assign accept  = start && (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);

  seqdiv_prep #(.DW(DW), .CW(CW)) u_prep (
    .mode(mode_in), .sgn(is_signed), .hi(dvd_hi), .lo(dvd_lo), .dvs(divisor),
    .dvd_mag(p_dvd), .dvs_mag(p_dvs), .q_neg(p_qneg), .r_neg(p_rneg),
    .dvs_zero(p_zero), .steps(p_steps)
  );

  seqdiv_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(state == ST_RUN),
    .dvd_in(p_dvd), .dvs_in(p_dvs), .quo(c_quo), .rem(c_rem)
  );

  seqdiv_post #(.DW(DW), .IW(IW)) u_post (
    .mode(mode_q), .sgn(sgn_q), .quo_mag(c_quo), .rem_mag(c_rem),
    .q_neg(qneg_q), .r_neg(rneg_q), .qi(qi_q), .ri(ri_q),
    .old_z(oz_q), .old_n(on_q), .q_data(f_qd), .r_data(f_rd),
    .q_we(f_qwe), .r_we(f_rwe), .z(f_z), .n(f_n), .v(f_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      mode_q   <= DM_WORD;
      sgn_q    <= 1'b0;
      qneg_q   <= 1'b0;
      rneg_q   <= 1'b0;
      dz_q     <= 1'b0;
      oz_q     <= 1'b0;
      on_q     <= 1'b0;
      qi_q     <= '0;
      ri_q     <= '0;
      done     <= 1'b0;
      div0_exc <= 1'b0;
      wq_en    <= 1'b0;
      wr_en    <= 1'b0;
      flag_we  <= 1'b0;
      wq_sel   <= '0;
      wr_sel   <= '0;
      wq_data  <= '0;
      wr_data  <= '0;
      flag_z   <= 1'b0;
      flag_n   <= 1'b0;
      flag_v   <= 1'b0;
      flag_c   <= 1'b0;
    end else begin
      done     <= 1'b0;
      div0_exc <= 1'b0;
      wq_en    <= 1'b0;
      wr_en    <= 1'b0;
      flag_we  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          mode_q <= mode_in;
          sgn_q  <= is_signed;
          qneg_q <= p_qneg;
          rneg_q <= p_rneg;
          dz_q   <= p_zero;
          oz_q   <= z_in;
          on_q   <= n_in;
          qi_q   <= q_idx;
          ri_q   <= r_idx;
          cnt    <= p_steps;
          state  <= p_zero ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (dz_q) begin
            div0_exc <= 1'b1;
          end else begin
            wq_en   <= f_qwe;
            wr_en   <= f_rwe;
            flag_we <= 1'b1;
            wq_sel  <= qi_q;
            wr_sel  <= ri_q;
            wq_data <= f_qd;
            wr_data <= f_rd;
            flag_z  <= f_z;
            flag_n  <= f_n;
            flag_v  <= f_v;
            flag_c  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seqdiv_chk.sv
module seqdiv_chk #(
  parameter int DW = 32,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    mode,
  input logic [DW-1:0] divisor,
  input logic          z_in,
  input logic          n_in,
  input logic          busy,
  input logic          done,
  input logic          div0_exc,
  input logic          wq_en,
  input logic [IW-1:0] wq_sel,
  input logic          wr_en,
  input logic [IW-1:0] wr_sel,
  input logic          flag_we,
  input logic          flag_z,
  input logic          flag_n,
  input logic          flag_v
);
  localparam int HW = DW / 2;
  localparam int LW = $clog2(2 * DW + 2);

  logic [1:0]    m_c;
  logic          zd_c, z_c, n_c;
  logic [LW-1:0] lat;
  logic [LW-1:0] lat_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c  <= 2'b00;
      zd_c <= 1'b0;
      z_c  <= 1'b0;
      n_c  <= 1'b0;
      lat  <= '0;
    end else if (start && !busy) begin
      m_c  <= mode;
      zd_c <= (mode == 2'b00) ? (divisor[HW-1:0] == '0) : (divisor == '0);
      z_c  <= z_in;
      n_c  <= n_in;
      lat  <= '0;
    end else if (busy) begin
      lat  <= lat + LW'(1);
    end
  end

  assign lat_exp = zd_c ? LW'(1) : ((m_c == 2'b10) ? LW'(2 * DW + 1) : LW'(DW + 1));

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r1_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_en || wr_en || flag_we || div0_exc) |-> done);
  a_r2_zero_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zd_c) |-> div0_exc);
  a_r2_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    div0_exc |-> (!wq_en && !wr_en && !flag_we));
  a_r3_word_no_rem: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_c == 2'b00) |-> !wr_en);
  a_r5_shared_reg: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_sel != wq_sel));
  a_r9_hold_zn: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && flag_v) |-> (flag_z == z_c && flag_n == n_c));
  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && flag_v) |-> (!wq_en && !wr_en));
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == lat_exp));
endmodule

bind seqdiv_unit seqdiv_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .divisor(divisor),
  .z_in(z_in), .n_in(n_in), .busy(busy), .done(done), .div0_exc(div0_exc),
  .wq_en(wq_en), .wq_sel(wq_sel), .wr_en(wr_en), .wr_sel(wr_sel),
  .flag_we(flag_we), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
);

// File: tb/sim_seqdiv_unit.sv
module sim_seqdiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        is_signed = 1'b0;
  logic [31:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic [2:0]  q_idx = '0, r_idx = '0;
  logic        z_in = 1'b0, n_in = 1'b0;
  logic        busy, done, div0_exc, wq_en, wr_en, flag_we, flag_z, flag_n, flag_v, flag_c;
  logic [2:0]  wq_sel, wr_sel;
  logic [31:0] wq_data, wr_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct {
    logic [1:0]  m;
    bit          exc, qwe, rwe, fwe, z, n, v;
    logic [31:0] qd, rd;
    logic [2:0]  qs, rs;
    int          lat;
    int          t0;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seqdiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_signed(is_signed),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor), .q_idx(q_idx), .r_idx(r_idx),
    .z_in(z_in), .n_in(n_in), .busy(busy), .done(done), .div0_exc(div0_exc),
    .wq_en(wq_en), .wq_sel(wq_sel), .wq_data(wq_data), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .flag_we(flag_we), .flag_z(flag_z), .flag_n(flag_n),
    .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic exp_t model(input logic [1:0] m, input bit s, input logic [31:0] hi,
                                 input logic [31:0] lo, input logic [31:0] dv,
                                 input logic [2:0] qi, input logic [2:0] ri,
                                 input bit oz, input bit on);
    exp_t e;
    logic signed [127:0] nn, dd, qq, rr;
    bit ov;
    e.m = m; e.exc = 0; e.qwe = 0; e.rwe = 0; e.fwe = 0; e.z = 0; e.n = 0; e.v = 0;
    e.qd = '0; e.rd = '0; e.qs = qi; e.rs = ri; e.t0 = 0;
    if (m == 2'b00) begin
      nn = s ? {{96{lo[31]}}, lo} : {96'b0, lo};
      dd = s ? {{112{dv[15]}}, dv[15:0]} : {112'b0, dv[15:0]};
    end else if (m == 2'b01) begin
      nn = s ? {{96{lo[31]}}, lo} : {96'b0, lo};
      dd = s ? {{96{dv[31]}}, dv} : {96'b0, dv};
    end else begin
      nn = s ? {{64{hi[31]}}, hi, lo} : {64'b0, hi, lo};
      dd = s ? {{96{dv[31]}}, dv} : {96'b0, dv};
    end
    if (dd == 0) begin
      e.exc = 1; e.lat = 2;
      return e;
    end
    qq = nn / dd;
    rr = nn % dd;
    if (m == 2'b00)
      ov = s ? (qq > 128'sd32767 || qq < -128'sd32768) : (qq > 128'sd65535);
    else
      ov = s ? (qq > 128'sd2147483647 || qq < -128'sd2147483648) : (qq > 128'sd4294967295);
    e.fwe = 1;
    e.v   = ov;
    e.qwe = !ov;
    e.rwe = !ov && (m != 2'b00) && (qi != ri);
    e.qd  = (m == 2'b00) ? {rr[15:0], qq[15:0]} : qq[31:0];
    e.rd  = rr[31:0];
    e.z   = ov ? oz : (qq[31:0] == 0);
    e.n   = ov ? on : ((m == 2'b00) ? qq[15] : qq[31]);
    e.lat = (m == 2'b10) ? 66 : 34;
    return e;
  endfunction

  task automatic issue(input logic [1:0] m, input bit s, input logic [31:0] hi,
                       input logic [31:0] lo, input logic [31:0] dv,
                       input logic [2:0] qi, input logic [2:0] ri, input bit oz, input bit on);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    mode = m; is_signed = s; dvd_hi = hi; dvd_lo = lo; divisor = dv;
    q_idx = qi; r_idx = ri; z_in = oz; n_in = on; start = 1'b1;
    e = model(m, s, hi, lo, dv, qi, ri, oz, on);
    e.t0 = cyc;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: compare each result against the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1 unexpected result", 64'd1, 64'd0);
      end else begin
        exp_t e;
        string dt;
        e = sb.pop_front();
        dt = (e.m == 2'b00) ? "R3" : ((e.m == 2'b01) ? "R5" : "R6");
        chk(busy == 1'b0, "R1 busy low with done", 64'(busy), 64'd0);
        chk(cyc - e.t0 == e.lat, "R11 latency", 64'(cyc - e.t0), 64'(e.lat));
        chk(div0_exc == e.exc, "R2 div0_exc", 64'(div0_exc), 64'(e.exc));
        chk(wq_en == e.qwe, "R10 wq_en", 64'(wq_en), 64'(e.qwe));
        chk(wr_en == e.rwe, "R10 wr_en", 64'(wr_en), 64'(e.rwe));
        chk(flag_we == e.fwe, "R8 flag_we", 64'(flag_we), 64'(e.fwe));
        if (e.qwe) begin
          chk(wq_data == e.qd, {dt, " quotient data"}, 64'(wq_data), 64'(e.qd));
          chk(wq_sel == e.qs, "R12 wq_sel", 64'(wq_sel), 64'(e.qs));
        end
        if (e.rwe) begin
          chk(wr_data == e.rd, {dt, " remainder data"}, 64'(wr_data), 64'(e.rd));
          chk(wr_sel == e.rs, "R12 wr_sel", 64'(wr_sel), 64'(e.rs));
        end
        if (e.fwe) begin
          chk(flag_c == 1'b0, "R8 flag_c", 64'(flag_c), 64'd0);
          chk(flag_v == e.v, "R8 flag_v", 64'(flag_v), 64'(e.v));
          chk(flag_z == e.z, "R9 flag_z", 64'(flag_z), 64'(e.z));
          chk(flag_n == e.n, "R9 flag_n", 64'(flag_n), 64'(e.n));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset idle", 64'({busy, done}), 64'd0);
    chk(!wq_en && !wr_en && !flag_we && !div0_exc, "R1 reset enables",
        64'({wq_en, wr_en, flag_we, div0_exc}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 word unsigned
    issue(2'b00, 0, 32'h0, 32'd100000, 32'd7, 3'd2, 3'd5, 0, 0);
    // R4 word unsigned overflow; Z/N must hold (R9)
    issue(2'b00, 0, 32'h0, 32'h0010_0000, 32'h0000_0001, 3'd1, 3'd1, 1, 1);
    // R7 word signed -7/2 -> q=-3 r=-1
    issue(2'b00, 1, 32'h0, 32'hFFFF_FFF9, 32'h0000_0002, 3'd3, 3'd4, 0, 0);
    // R4 word signed overflow 40000/1
    issue(2'b00, 1, 32'h0, 32'd40000, 32'h0000_0001, 3'd3, 3'd4, 0, 1);
    // R4 word signed boundary -65536/2 = -32768 fits
    issue(2'b00, 1, 32'h0, 32'hFFFF_0000, 32'h0000_0002, 3'd0, 3'd4, 0, 0);
    // R2 word: only low 16 bits count as divisor
    issue(2'b00, 0, 32'h0, 32'd1234, 32'h0001_0000, 3'd0, 3'd1, 0, 0);
    // R5 long unsigned, distinct and shared registers
    issue(2'b01, 0, 32'h0, 32'hFFFF_FFFF, 32'd3, 3'd2, 3'd6, 0, 0);
    issue(2'b01, 0, 32'h0, 32'd1000, 32'd7, 3'd5, 3'd5, 0, 0);
    // R5 long signed overflow 0x80000000 / -1
    issue(2'b01, 1, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 3'd1, 3'd2, 1, 0);
    // R7 long signed -100/7 -> -14 r -2
    issue(2'b01, 1, 32'h0, 32'hFFFF_FF9C, 32'd7, 3'd1, 3'd2, 0, 0);
    // R9 zero quotient sets Z
    issue(2'b01, 0, 32'h0, 32'd5, 32'd7, 3'd1, 3'd2, 0, 1);
    // R6 quad unsigned fits / overflows
    issue(2'b10, 0, 32'h0000_0001, 32'h0, 32'd2, 3'd1, 3'd0, 0, 0);
    issue(2'b10, 0, 32'h0000_0002, 32'h0, 32'd2, 3'd1, 3'd0, 0, 0);
    // R6 quad signed: -2^32/2 fits, -2^32/1 overflows
    issue(2'b10, 1, 32'hFFFF_FFFF, 32'h0, 32'd2, 3'd1, 3'd0, 0, 0);
    issue(2'b10, 1, 32'hFFFF_FFFF, 32'h0, 32'd1, 3'd1, 3'd0, 1, 1);
    // R6 quad same register: quotient wins
    issue(2'b10, 0, 32'h0000_0000, 32'd77777, 32'd10, 3'd4, 3'd4, 0, 0);
    // R2 quad zero divisor
    issue(2'b10, 1, 32'h1, 32'h2, 32'h0, 3'd4, 3'd3, 0, 0);

    // R1 start during busy is ignored
    issue(2'b01, 0, 32'h0, 32'd900, 32'd30, 3'd1, 3'd2, 0, 0);
    chk(busy == 1'b1, "R1 busy after accept", 64'(busy), 64'd1);
    mode = 2'b00; dvd_lo = 32'd5; divisor = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b, c;
      logic [1:0]  m;
      a = $urandom; b = $urandom; c = $urandom;
      m = 2'($urandom % 3);
      if (i % 4 == 0) c = c >> ($urandom % 31);
      issue(m, bit'($urandom % 2), (m == 2'b10) ? (a >> ($urandom % 32)) : 32'h0, b, c,
            3'($urandom), 3'($urandom), bit'($urandom % 2), bit'($urandom % 2));
    end

    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R1 all results seen", 64'(sb.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule